// File: doc/BRIEF.md
# Descriptor Condition Evaluation Unit

This block decides, for the descriptor a DMA channel is executing, whether the channel should stall, whether it should signal an interrupt, and where it should fetch its next descriptor. Three 2-bit mode fields in the descriptor command word select one of four policies for each decision. These policies are: never, always, when a condition holds, and when it does not hold. Each decision has its own selector register. The selector holds a 4-bit mask and a 4-bit compare value, which are applied to the channel's 4-bit device-status nibble.

The channel sequencer pulses `eval_i` once per descriptor completion. The unit then does one of two things. If the stall decision is true, it raises `wait_o` and leaves the pointer alone. Otherwise it publishes the next command pointer and the branch-taken flag, and it pulses the interrupt if the interrupt decision is true. A branch loads the descriptor's 32-bit dependent word as the new pointer. Sequential advance adds the 16-byte descriptor size. All outputs are registered and change on the clock edge that samples `eval_i`.

Top module: `desc_cond_unit`

## Requirements
- R1: After a synchronous reset, `irq_o`, `wait_o`, `ptr_vld_o`, `br_taken_o` and `nxt_ptr_o` are all zero.
- R2: The command word carries three mode fields. The interrupt mode is in bits 5:4, the branch mode in bits 3:2 and the wait mode in bits 1:0. Each field is encoded 00 never, 01 when the condition holds, 10 when it does not hold, and 11 always.
- R3: A decision's condition holds when (status AND mask) equals (value AND mask). The mask is selector bits 19:16 and the value is selector bits 3:0. A zero mask makes the condition hold for any status.
- R4: In the never and always modes the selector contents and the status have no effect on the decision.
- R5: When the wait decision is true at an evaluation, `wait_o` becomes 1. In that case no pointer update is made, no interrupt is raised, and `nxt_ptr_o` and `br_taken_o` keep their values. Otherwise `wait_o` becomes 0.
- R6: `irq_o` is high for exactly one cycle, in the cycle after an evaluation edge, and only if the wait decision is false and the interrupt decision is true.
- R7: A true branch decision, with no wait, sets `nxt_ptr_o` to the dependent word and sets `br_taken_o` to 1.
- R8: A false branch decision, with no wait, sets `nxt_ptr_o` to the current pointer plus 16, modulo 2^32, and clears `br_taken_o`.
- R9: Each decision compares against its own selector input. These are `irq_sel_i` for the interrupt, `wait_sel_i` for the wait and `br_sel_i` for the branch.
- R10: `ptr_vld_o` pulses for one cycle after each evaluation that is not stalled. Without `eval_i`, no output other than these pulses changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_i | input | 1 | Evaluate strobe, one per descriptor completion |
| cmd_i | input | 16 | Descriptor command word carrying the mode fields |
| dep_i | input | 32 | Descriptor dependent word, used as the branch target |
| cur_ptr_i | input | 32 | Address of the descriptor being evaluated |
| dev_stat_i | input | 4 | Device-status nibble of the channel |
| irq_sel_i | input | 32 | Interrupt selector (mask 19:16, value 3:0) |
| wait_sel_i | input | 32 | Wait selector (mask 19:16, value 3:0) |
| br_sel_i | input | 32 | Branch selector (mask 19:16, value 3:0) |
| irq_o | output | 1 | One-cycle interrupt pulse |
| wait_o | output | 1 | Stall flag from the latest evaluation |
| nxt_ptr_o | output | 32 | Next command pointer |
| ptr_vld_o | output | 1 | One-cycle pulse marking a pointer update |
| br_taken_o | output | 1 | Branch-taken status flag |

## Verification
An internal fault shows at the ports one cycle after the evaluation edge. The faults that matter are a swapped mode field, a mask taken from the wrong bits, a selector routed to the wrong decision, or an inverted mode. Any of these produces a wrong pointer, a missing or spurious interrupt pulse, or a flipped branch flag. A stale branch flag, or a pointer update leaking through a stall, only shows when the bench compares held outputs across an evaluation that should not touch them. The directed scenarios therefore follow a stall or an idle stretch with a check of the unchanged values.

// File: rtl/desc_cond_pkg.sv
package desc_cond_pkg;
  typedef enum logic [1:0] {
    MODE_OFF      = 2'b00,
    MODE_ON_MATCH = 2'b01,
    MODE_ON_MISS  = 2'b10,
    MODE_FORCE    = 2'b11
  } cond_mode_e;

  localparam int unsigned DEC_WAIT = 0;
  localparam int unsigned DEC_BR   = 1;
  localparam int unsigned DEC_IRQ  = 2;
  localparam int unsigned NUM_DEC  = 3;

  function automatic logic resolve_mode(input cond_mode_e mode, input logic hit);
    case (mode)
      MODE_OFF:      resolve_mode = 1'b0;
      MODE_ON_MATCH: resolve_mode = hit;
      MODE_ON_MISS:  resolve_mode = ~hit;
      default:       resolve_mode = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/cond_match.sv
module cond_match
  import desc_cond_pkg::*;
#(
  parameter int unsigned NIB_W    = 4,
  parameter int unsigned SEL_W    = 32,
  parameter int unsigned MASK_LSB = 16
) (
  input  logic [1:0]       mode_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [NIB_W-1:0] stat_i,
  output logic             take_o
);
  localparam int unsigned MASK_MSB = MASK_LSB + NIB_W - 1;

  logic [NIB_W-1:0] mask;
  logic [NIB_W-1:0] val;
  logic             hit;

  assign mask = sel_i[MASK_MSB:MASK_LSB];
  assign val  = sel_i[NIB_W-1:0];
  assign hit  = ((stat_i & mask) == (val & mask));

  always_comb begin
    take_o = resolve_mode(cond_mode_e'(mode_i), hit);
  end
endmodule

// File: rtl/ptr_next.sv
module ptr_next #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned STEP   = 16
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [ADDR_W-1:0] dep_i,
  input  logic              branch_i,
  output logic [ADDR_W-1:0] nxt_o
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  always_comb begin
    if (branch_i) nxt_o = dep_i;
    else          nxt_o = cur_i + STEP_V;
  end
endmodule

// File: rtl/desc_cond_unit.sv
module desc_cond_unit
  import desc_cond_pkg::*;
#(
  parameter int unsigned CMD_W      = 16,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned SEL_W      = 32,
  parameter int unsigned NIB_W      = 4,
  parameter int unsigned MASK_LSB   = 16,
  parameter int unsigned DESC_BYTES = 16,
  parameter int unsigned WAIT_LSB   = 0,
  parameter int unsigned BR_LSB     = 2,
  parameter int unsigned IRQ_LSB    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eval_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [ADDR_W-1:0] dep_i,
  input  logic [ADDR_W-1:0] cur_ptr_i,
  input  logic [NIB_W-1:0]  dev_stat_i,
  input  logic [SEL_W-1:0]  irq_sel_i,
  input  logic [SEL_W-1:0]  wait_sel_i,
  input  logic [SEL_W-1:0]  br_sel_i,
  output logic              irq_o,
  output logic              wait_o,
  output logic [ADDR_W-1:0] nxt_ptr_o,
  output logic              ptr_vld_o,
  output logic              br_taken_o
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(DESC_BYTES);

  logic [NUM_DEC-1:0][1:0]       mode_arr;
  logic [NUM_DEC-1:0][SEL_W-1:0] sel_arr;
  logic [NUM_DEC-1:0]            take;
  logic [ADDR_W-1:0]             nxt_ptr;

  assign mode_arr[DEC_WAIT] = cmd_i[WAIT_LSB+1:WAIT_LSB];
  assign mode_arr[DEC_BR]   = cmd_i[BR_LSB+1:BR_LSB];
  assign mode_arr[DEC_IRQ]  = cmd_i[IRQ_LSB+1:IRQ_LSB];
  assign sel_arr[DEC_WAIT]  = wait_sel_i;
  assign sel_arr[DEC_BR]    = br_sel_i;
  assign sel_arr[DEC_IRQ]   = irq_sel_i;

  for (genvar k = 0; k < NUM_DEC; k++) begin : g_dec
    cond_match #(
      .NIB_W   (NIB_W),
      .SEL_W   (SEL_W),
      .MASK_LSB(MASK_LSB)
    ) u_match (
      .mode_i(mode_arr[k]),
      .sel_i (sel_arr[k]),
      .stat_i(dev_stat_i),
      .take_o(take[k])
    );
  end

  ptr_next #(
    .ADDR_W(ADDR_W),
    .STEP  (DESC_BYTES)
  ) u_ptr (
    .cur_i   (cur_ptr_i),
    .dep_i   (dep_i),
    .branch_i(take[DEC_BR]),
    .nxt_o   (nxt_ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o      <= 1'b0;
      wait_o     <= 1'b0;
      nxt_ptr_o  <= '0;
      ptr_vld_o  <= 1'b0;
      br_taken_o <= 1'b0;
    end else begin
      irq_o     <= 1'b0;
      ptr_vld_o <= 1'b0;
      if (eval_i) begin
        wait_o <= take[DEC_WAIT];
        if (!take[DEC_WAIT]) begin
          irq_o      <= take[DEC_IRQ];
          ptr_vld_o  <= 1'b1;
          nxt_ptr_o  <= nxt_ptr;
          br_taken_o <= take[DEC_BR];
        end
      end
    end
  end

  // R6
  irq_after_eval_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(eval_i));

  // R5
  wait_blocks_update_chk: assert property (@(posedge clk) disable iff (rst)
    wait_o |-> (!ptr_vld_o && !irq_o));

  // R7
  branch_target_chk: assert property (@(posedge clk) disable iff (rst)
    (ptr_vld_o && br_taken_o) |-> (nxt_ptr_o == $past(dep_i)));

  // R8
  seq_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (ptr_vld_o && !br_taken_o) |-> (nxt_ptr_o == $past(cur_ptr_i) + STEP_V));

  // R10
  hold_without_update_chk: assert property (@(posedge clk) disable iff (rst)
    !ptr_vld_o |-> ($stable(br_taken_o) && $stable(nxt_ptr_o)));

  // R10
  vld_needs_eval_chk: assert property (@(posedge clk) disable iff (rst)
    ptr_vld_o |-> $past(eval_i));
endmodule

// File: tb/desc_cond_unit_tb.sv
module desc_cond_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        eval_i;
  logic [15:0] cmd_i;
  logic [31:0] dep_i;
  logic [31:0] cur_ptr_i;
  logic [3:0]  dev_stat_i;
  logic [31:0] irq_sel_i;
  logic [31:0] wait_sel_i;
  logic [31:0] br_sel_i;
  logic        irq_o;
  logic        wait_o;
  logic [31:0] nxt_ptr_o;
  logic        ptr_vld_o;
  logic        br_taken_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  desc_cond_unit dut_i (
    .clk(clk), .rst(rst), .eval_i(eval_i), .cmd_i(cmd_i), .dep_i(dep_i),
    .cur_ptr_i(cur_ptr_i), .dev_stat_i(dev_stat_i), .irq_sel_i(irq_sel_i),
    .wait_sel_i(wait_sel_i), .br_sel_i(br_sel_i), .irq_o(irq_o),
    .wait_o(wait_o), .nxt_ptr_o(nxt_ptr_o), .ptr_vld_o(ptr_vld_o),
    .br_taken_o(br_taken_o)
  );

  // mode codes: 0 never, 1 on match, 2 on miss, 3 always
  function automatic logic [15:0] mk_cmd(input logic [1:0] irq, input logic [1:0] br,
                                         input logic [1:0] wt);
    mk_cmd = {10'b0, irq, br, wt};
  endfunction

  function automatic logic [31:0] mk_sel(input logic [3:0] mask, input logic [3:0] val);
    mk_sel = {12'b0, mask, 12'b0, val};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_eval(input logic [15:0] cmd, input logic [31:0] dep,
                          input logic [31:0] cur, input logic [31:0] isel,
                          input logic [31:0] wsel, input logic [31:0] bsel,
                          input logic [3:0] stat);
    @(negedge clk);
    cmd_i = cmd; dep_i = dep; cur_ptr_i = cur; irq_sel_i = isel;
    wait_sel_i = wsel; br_sel_i = bsel; dev_stat_i = stat; eval_i = 1'b1;
    @(negedge clk);
    eval_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 irq", {31'b0, irq_o}, 0);
    chk("R1 wait", {31'b0, wait_o}, 0);
    chk("R1 vld", {31'b0, ptr_vld_o}, 0);
    chk("R1 bt", {31'b0, br_taken_o}, 0);
    chk("R1 ptr", nxt_ptr_o, 0);
  endtask

  task automatic t_seq;
    run_eval(mk_cmd(2'd0, 2'd0, 2'd0), 32'hDEAD_0000, 32'h0000_0100, 0, 0, 0, 4'h0);
    chk("R8 ptr", nxt_ptr_o, 32'h0000_0110);
    chk("R8 bt", {31'b0, br_taken_o}, 0);
    chk("R10 vld", {31'b0, ptr_vld_o}, 1);
    chk("R2 no irq", {31'b0, irq_o}, 0);
    @(negedge clk);
    chk("R10 vld pulse", {31'b0, ptr_vld_o}, 0);
  endtask

  task automatic t_branch;
    run_eval(mk_cmd(2'd0, 2'd3, 2'd0), 32'hBEEF_0040, 32'h0000_0200, 0, 0,
             mk_sel(4'hF, 4'h9), 4'h0);
    chk("R7 ptr", nxt_ptr_o, 32'hBEEF_0040);
    chk("R7 bt", {31'b0, br_taken_o}, 1);
    chk("R4 force ignores sel", {31'b0, br_taken_o}, 1);
    run_eval(mk_cmd(2'd0, 2'd0, 2'd0), 32'h0, 32'hBEEF_0040, 0, 0, 0, 4'h0);
    chk("R8 bt cleared", {31'b0, br_taken_o}, 0);
    chk("R8 ptr after branch", nxt_ptr_o, 32'hBEEF_0050);
  endtask

  task automatic t_irq;
    run_eval(mk_cmd(2'd3, 2'd0, 2'd0), 0, 32'h300, mk_sel(4'hF, 4'h7), 0, 0, 4'h0);
    chk("R6 irq always", {31'b0, irq_o}, 1);
    @(negedge clk);
    chk("R6 irq one cycle", {31'b0, irq_o}, 0);
    run_eval(mk_cmd(2'd0, 2'd0, 2'd0), 0, 32'h300, mk_sel(4'h0, 4'h0), 0, 0, 4'h0);
    chk("R4 irq never", {31'b0, irq_o}, 0);
  endtask

  task automatic t_cond;
    run_eval(mk_cmd(2'd1, 2'd0, 2'd0), 0, 32'h400, mk_sel(4'hF, 4'h5), 0, 0, 4'h5);
    chk("R3 match full mask", {31'b0, irq_o}, 1);
    run_eval(mk_cmd(2'd1, 2'd0, 2'd0), 0, 32'h400, mk_sel(4'hF, 4'h5), 0, 0, 4'h4);
    chk("R3 miss full mask", {31'b0, irq_o}, 0);
    run_eval(mk_cmd(2'd2, 2'd0, 2'd0), 0, 32'h400, mk_sel(4'hF, 4'h5), 0, 0, 4'h4);
    chk("R2 on-miss mode", {31'b0, irq_o}, 1);
    run_eval(mk_cmd(2'd1, 2'd0, 2'd0), 0, 32'h400, mk_sel(4'h3, 4'h1), 0, 0, 4'hD);
    chk("R3 partial mask", {31'b0, irq_o}, 1);
    run_eval(mk_cmd(2'd0, 2'd1, 2'd0), 32'h0000_0800, 32'h400, 0, 0,
             mk_sel(4'h0, 4'hA), 4'h3);
    chk("R3 zero mask branch", nxt_ptr_o, 32'h0000_0800);
    run_eval(mk_cmd(2'd0, 2'd2, 2'd0), 32'h0000_0900, 32'h400, 0, 0,
             mk_sel(4'h0, 4'hA), 4'h3);
    chk("R2 branch on-miss", nxt_ptr_o, 32'h0000_0410);
  endtask

  task automatic t_wait;
    run_eval(mk_cmd(2'd0, 2'd3, 2'd0), 32'h0000_1000, 32'h500, 0, 0, 0, 4'h0);
    run_eval(mk_cmd(2'd3, 2'd0, 2'd3), 32'h0, 32'h1000, 0, 0, 0, 4'h0);
    chk("R5 wait set", {31'b0, wait_o}, 1);
    chk("R5 no irq", {31'b0, irq_o}, 0);
    chk("R5 no vld", {31'b0, ptr_vld_o}, 0);
    chk("R5 ptr held", nxt_ptr_o, 32'h0000_1000);
    chk("R5 bt held", {31'b0, br_taken_o}, 1);
    run_eval(mk_cmd(2'd0, 2'd0, 2'd1), 32'h0, 32'h1000, 0, mk_sel(4'hF, 4'h2), 0, 4'h1);
    chk("R5 wait cleared", {31'b0, wait_o}, 0);
    chk("R5 advance after wait", nxt_ptr_o, 32'h0000_1010);
  endtask

  task automatic t_own_sel;
    run_eval(mk_cmd(2'd1, 2'd1, 2'd1), 32'h0000_2000, 32'h600,
             mk_sel(4'hF, 4'h0), mk_sel(4'hF, 4'h8), mk_sel(4'hF, 4'h3), 4'h3);
    chk("R9 branch own sel", nxt_ptr_o, 32'h0000_2000);
    chk("R9 irq own sel", {31'b0, irq_o}, 0);
    chk("R9 wait own sel", {31'b0, wait_o}, 0);
  endtask

  task automatic t_wrap_hold;
    run_eval(mk_cmd(2'd0, 2'd0, 2'd0), 32'h0, 32'hFFFF_FFF0, 0, 0, 0, 4'h0);
    chk("R8 wrap", nxt_ptr_o, 32'h0000_0000);
    @(negedge clk);
    cmd_i = mk_cmd(2'd3, 2'd3, 2'd0); dep_i = 32'h1234_5678; cur_ptr_i = 32'h700;
    repeat (3) @(negedge clk);
    chk("R10 ptr held", nxt_ptr_o, 32'h0000_0000);
    chk("R10 bt held", {31'b0, br_taken_o}, 0);
    chk("R10 no irq", {31'b0, irq_o}, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; eval_i = 1'b0; cmd_i = '0; dep_i = '0; cur_ptr_i = '0;
    dev_stat_i = '0; irq_sel_i = '0; wait_sel_i = '0; br_sel_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_seq();
    t_branch();
    t_irq();
    t_cond();
    t_wait();
    t_own_sel();
    t_wrap_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule